// File: doc/BRIEF.md
# Decade Result Counter with Range Latch

This block counts the result of a dual-slope conversion. It keeps a signed magnitude as a chain of binary-coded decimal digit stages. A comparator-gated enable makes it step once per clock. The sequencer sets the count direction for each integration phase. The polarity is held in a separate sign bit, so the stored value is always a sign and a plain decimal magnitude, and a negative zero never appears.

An internal conversion timer divides time into frames of `CONV_LEN` clocks. The counter clears at the start of each frame. For the last `LATCH_LEN` clocks of the frame the active-low latch strobe is driven, the count is frozen, and the value is copied into a display register. At the same moment two range flags are computed from the copied value:
- Over range: the magnitude exceeds 19,999.
- Under range: the magnitude is below 1000.

An external hold input stops the display and the flags from updating. A transparent input makes the display follow the running count on every clock.

Top module: `dec_result_ctr`

## Requirements
- R1: While `rst_ni` is low, the display digits, the display sign and both flags are zero, and `latch_n_o` is high.
- R2: With `cmp_i` high, each clock moves the magnitude by one in decimal. Digit k sits at bits 4k+3:4k of `disp_bcd_o`, digit 0 is the least significant, and every digit stays in 0..9.
- R3: The sign is held as sign-magnitude (`disp_neg_o`=1 means negative).
  - Stepping away from zero in the negative direction sets the sign and then increases the magnitude.
  - Stepping from -1 toward zero gives +0.
  - `up_i`=1 moves toward positive.
- R4: The count changes only on clocks where `cmp_i` is high and the strobe is not asserted. During the strobe window the count is frozen.
- R5: Each conversion lasts `CONV_LEN` clocks and the count is cleared at its start. `latch_n_o` is low for exactly the last `LATCH_LEN` clocks of each conversion.
- R6: The display and both flags take the final count in the same cycle that `latch_n_o` falls. They keep that value until the next fall.
- R7: `over_o` is 1 when the latched magnitude is greater than 19,999, and 0 at 19,999 or less.
- R8: `under_o` is 1 when the latched magnitude is below 1000, and 0 at 1000 or more.
- R9: If `hold_i` is high at the capture clock, the display, the sign and both flags keep their previous values. This takes priority over transparent mode.
- R10: While `transp_i` is high and `hold_i` is low, the display is updated every clock with the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 1 | Comparator gate; counts while high |
| up_i | input | 1 | Direction: 1 toward positive, 0 toward negative |
| hold_i | input | 1 | Freeze display and flags |
| transp_i | input | 1 | Display follows live count |
| latch_n_o | output | 1 | Latch strobe, low in last LATCH_LEN clocks of a conversion |
| disp_bcd_o | output | NDIG*4 | Displayed magnitude, BCD |
| disp_neg_o | output | 1 | Displayed sign, 1 = negative |
| over_o | output | 1 | Latched magnitude above 19,999 |
| under_o | output | 1 | Latched magnitude below 1000 |

## Verification
The bench targets the flag thresholds directly.
- Magnitudes of 999 and 1000 separate an under-range test that uses "at or below" from the correct strict test.
- A magnitude of 20000, reached through a carry that crosses four digits, catches a broken carry chain and an over-range test that only checks the top digit.

Two rows cover sign handling.
- One counts down past zero. A design that wraps to 999999 or keeps +0 after a down step fails it.
- The other climbs back from -3 to zero. A design that leaves a negative zero fails it.

Further directed conversions cover the remaining controls.
- Transparent mode: a design that updates the display only at the strobe fails.
- Clocks held inside the strobe window: a design that keeps counting there fails.
- A held frame: a design that ignores `hold_i` overwrites the old reading and flags, and fails.

// File: rtl/dec_ctr_pkg.sv
package dec_ctr_pkg;
  typedef logic [3:0] bcd_t;
  localparam bcd_t BCD_MAX = 4'd9;
endpackage

// File: rtl/dec_conv_timer.sv
module dec_conv_timer #(
  parameter int CONV_LEN  = 4000,
  parameter int LATCH_LEN = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic win_o,   // latch window active
  output logic cap_o,   // last counting clock
  output logic wrap_o   // last clock of conversion
);
  localparam int CW = $clog2(CONV_LEN);
  localparam int WS = CONV_LEN - LATCH_LEN;

  logic [CW-1:0] conv_q;

  assign wrap_o = (conv_q == CW'(CONV_LEN - 1));
  assign win_o  = (conv_q >= CW'(WS));
  assign cap_o  = (conv_q == CW'(WS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     conv_q <= '0;
    else if (wrap_o) conv_q <= '0;
    else             conv_q <= conv_q + 1'b1;
  end
endmodule

// File: rtl/dec_bcd_stage.sv
module dec_bcd_stage
  import dec_ctr_pkg::*;
(
  input  bcd_t d_i,
  input  logic en_i,
  input  logic up_i,
  output bcd_t d_o,
  output logic cy_o
);
  logic edge_val;

  assign edge_val = up_i ? (d_i == BCD_MAX) : (d_i == '0);
  assign cy_o     = en_i & edge_val;

  always_comb begin
    d_o = d_i;
    if (en_i) begin
      if (up_i) d_o = edge_val ? bcd_t'(0) : d_i + 4'd1;
      else      d_o = edge_val ? BCD_MAX : d_i - 4'd1;
    end
  end
endmodule

// File: rtl/dec_range_det.sv
module dec_range_det
  import dec_ctr_pkg::*;
#(
  parameter int NDIG = 6
) (
  input  bcd_t [NDIG-1:0] mag_i,
  output logic            over_o,
  output logic            under_o
);
  logic hi_nz;

  always_comb begin
    hi_nz = 1'b0;
    for (int i = 5; i < NDIG; i++) hi_nz |= (mag_i[i] != '0);
  end

  // > 19999 : any digit above ten-thousands, or ten-thousands >= 2
  assign over_o  = hi_nz | (mag_i[4] >= 4'd2);
  // < 1000  : thousands and above all zero
  assign under_o = ~hi_nz & (mag_i[4] == '0) & (mag_i[3] == '0);
endmodule

// File: rtl/dec_result_ctr.sv
module dec_result_ctr
  import dec_ctr_pkg::*;
#(
  parameter int NDIG      = 6,
  parameter int CONV_LEN  = 4000,
  parameter int LATCH_LEN = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_i,
  input  logic              up_i,
  input  logic              hold_i,
  input  logic              transp_i,
  output logic              latch_n_o,
  output logic [NDIG*4-1:0] disp_bcd_o,
  output logic              disp_neg_o,
  output logic              over_o,
  output logic              under_o
);
  logic win, cap, wrap;

  dec_conv_timer #(.CONV_LEN(CONV_LEN), .LATCH_LEN(LATCH_LEN)) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .win_o (win),
    .cap_o (cap),
    .wrap_o(wrap)
  );

  bcd_t [NDIG-1:0] cnt_q, cnt_step, cnt_nx, cnt_d;
  logic            sign_q, sign_nx, sign_d;
  logic [NDIG:0]   cy;
  logic            step, mag_zero, step_zero, mag_up;

  assign step     = cmp_i & ~win;
  assign mag_zero = (cnt_q == '0);
  // magnitude grows when moving away from zero
  assign mag_up   = (up_i & ~sign_q) | (~up_i & (sign_q | mag_zero));
  assign cy[0]    = step;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    dec_bcd_stage i_stage (
      .d_i (cnt_q[g]),
      .en_i(cy[g]),
      .up_i(mag_up),
      .d_o (cnt_step[g]),
      .cy_o(cy[g+1])
    );
  end

  assign step_zero = (cnt_step == '0);
  // saturate at full scale rather than wrap
  assign cnt_nx    = cy[NDIG] ? cnt_q : cnt_step;

  always_comb begin
    sign_nx = sign_q;
    if (step) begin
      if (~up_i & ~sign_q & mag_zero)      sign_nx = 1'b1;
      else if (up_i & sign_q & step_zero)  sign_nx = 1'b0;
    end
  end

  assign cnt_d  = wrap ? '0 : cnt_nx;
  assign sign_d = wrap ? 1'b0 : sign_nx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sign_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sign_q <= sign_d;
    end
  end

  logic ov_d, un_d;

  dec_range_det #(.NDIG(NDIG)) i_range (
    .mag_i  (cnt_d),
    .over_o (ov_d),
    .under_o(un_d)
  );

  bcd_t [NDIG-1:0] disp_q;
  logic            disp_neg_q, over_q, under_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_q     <= '0;
      disp_neg_q <= 1'b0;
      over_q     <= 1'b0;
      under_q    <= 1'b0;
    end else if (!hold_i) begin
      if (cap || transp_i) begin
        disp_q     <= cnt_d;
        disp_neg_q <= sign_d;
      end
      if (cap) begin
        over_q  <= ov_d;
        under_q <= un_d;
      end
    end
  end

  assign latch_n_o  = ~win;
  assign disp_bcd_o = disp_q;
  assign disp_neg_o = disp_neg_q;
  assign over_o     = over_q;
  assign under_o    = under_q;
endmodule

// File: rtl/dec_result_ctr_chk.sv
module dec_result_ctr_chk #(
  parameter int NDIG      = 6,
  parameter int LATCH_LEN = 100
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hold_i,
  input logic              transp_i,
  input logic              latch_n_o,
  input logic [NDIG*4-1:0] disp_bcd_o,
  input logic              disp_neg_o,
  input logic              over_o,
  input logic              under_o,
  input logic [NDIG*4-1:0] cnt_i
);
  localparam int LW = $clog2(LATCH_LEN + 1) + 1;

  logic [LW-1:0] low_cnt;
  logic          bcd_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         low_cnt <= '0;
    else if (!latch_n_o) low_cnt <= low_cnt + 1'b1;
    else                 low_cnt <= '0;
  end

  always_comb begin
    bcd_bad = 1'b0;
    for (int i = 0; i < NDIG; i++) bcd_bad |= (disp_bcd_o[4*i +: 4] > 4'd9);
  end

  AST_BCD_DIGIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bcd_bad); // R2

  AST_NO_NEG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_neg_o |-> (disp_bcd_o != '0)); // R3

  AST_WIN_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!latch_n_o && $past(!latch_n_o)) |-> $stable(cnt_i)); // R4

  AST_STROBE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_n_o) |-> (low_cnt == LW'(LATCH_LEN))); // R5

  AST_FLAGS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(latch_n_o) |-> ($stable(over_o) && $stable(under_o))); // R6

  AST_DISP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$fell(latch_n_o) && !$past(transp_i)) |-> ($stable(disp_bcd_o) && $stable(disp_neg_o))); // R6

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(over_o && under_o)); // R7

  AST_HOLD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hold_i) |-> ($stable(disp_bcd_o) && $stable(disp_neg_o) && $stable(over_o) && $stable(under_o))); // R9
endmodule

bind dec_result_ctr dec_result_ctr_chk #(.NDIG(NDIG), .LATCH_LEN(LATCH_LEN)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hold_i    (hold_i),
  .transp_i  (transp_i),
  .latch_n_o (latch_n_o),
  .disp_bcd_o(disp_bcd_o),
  .disp_neg_o(disp_neg_o),
  .over_o    (over_o),
  .under_o   (under_o),
  .cnt_i     (cnt_q)
);

// File: tb/test_dec_result_ctr.sv
module test_dec_result_ctr;
  localparam int NDIG      = 6;
  localparam int CONV_LEN  = 20010;
  localparam int LATCH_LEN = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cmp_i = 1'b0, up_i = 1'b1, hold_i = 1'b0, transp_i = 1'b0;
  logic latch_n_o, disp_neg_o, over_o, under_o;
  logic [NDIG*4-1:0] disp_bcd_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dec_result_ctr #(.NDIG(NDIG), .CONV_LEN(CONV_LEN), .LATCH_LEN(LATCH_LEN)) i_dec_result_ctr (
    .clk_i, .rst_ni, .cmp_i, .up_i, .hold_i, .transp_i,
    .latch_n_o, .disp_bcd_o, .disp_neg_o, .over_o, .under_o
  );

  typedef struct packed {
    logic first_up;
    int   n1;
    int   n2;
    logic neg;
    int   mag;
    logic ov;
    logic un;
  } row_t;

  localparam row_t TBL [6] = '{
    '{1'b1, 20000,   0, 1'b0, 20000, 1'b1, 1'b0},
    '{1'b1,   999,   0, 1'b0,   999, 1'b0, 1'b1},
    '{1'b1,  1000,   0, 1'b0,  1000, 1'b0, 1'b0},
    '{1'b1,     5,  12, 1'b1,     7, 1'b0, 1'b1},
    '{1'b0,     3,   3, 1'b0,     0, 1'b0, 1'b1},
    '{1'b0,  1500, 200, 1'b1,  1300, 1'b0, 1'b0}
  };

  function automatic int bcd2int(logic [NDIG*4-1:0] v);
    int r = 0;
    for (int k = NDIG - 1; k >= 0; k--) r = r * 10 + int'(v[4*k +: 4]);
    return r;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_disp(string req, logic neg, int mag, logic ov, logic un);
    chk(req, "magnitude", bcd2int(disp_bcd_o), mag);
    chk(req, "sign", int'(disp_neg_o), int'(neg));
    chk(req, "over", int'(over_o), int'(ov));
    chk(req, "under", int'(under_o), int'(un));
  endtask

  task automatic to_next_conv();
    @(posedge latch_n_o);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1", "latch_n", int'(latch_n_o), 1);
    chk_disp("R1", 1'b0, 0, 1'b0, 1'b0);
    rst_ni = 1'b1;  // now at a negedge inside the first conversion clock

    // R2 R3 R5 R6 R7 R8: table of conversions
    foreach (TBL[i]) begin
      cmp_i = 1'b1;
      up_i  = TBL[i].first_up;
      repeat (TBL[i].n1) @(negedge clk_i);
      up_i  = ~TBL[i].first_up;
      repeat (TBL[i].n2) @(negedge clk_i);
      cmp_i = 1'b0;
      @(negedge latch_n_o);
      @(negedge clk_i);
      chk_disp($sformatf("R6 row%0d", i), TBL[i].neg, TBL[i].mag, TBL[i].ov, TBL[i].un);
      to_next_conv();
    end

    // R10: transparent display follows live count
    transp_i = 1'b1;
    cmp_i = 1'b1; up_i = 1'b1;
    repeat (37) @(negedge clk_i);
    chk("R10", "live magnitude", bcd2int(disp_bcd_o), 37);
    chk("R10", "live sign", int'(disp_neg_o), 0);
    up_i = 1'b0;
    repeat (40) @(negedge clk_i);
    chk("R10", "live magnitude", bcd2int(disp_bcd_o), 3);
    chk("R3", "live sign", int'(disp_neg_o), 1);
    cmp_i = 1'b0;
    @(negedge latch_n_o);
    @(negedge clk_i);
    // R4: gate open inside window must not move count
    cmp_i = 1'b1; up_i = 1'b1;
    repeat (3) @(negedge clk_i);
    cmp_i = 1'b0;
    chk("R4", "frozen magnitude", bcd2int(disp_bcd_o), 3);
    chk("R4", "frozen sign", int'(disp_neg_o), 1);
    chk("R8", "under", int'(under_o), 1);
    transp_i = 1'b0;
    to_next_conv();

    // R9: hold keeps previous reading and flags
    hold_i = 1'b1;
    cmp_i = 1'b1; up_i = 1'b1;
    repeat (2000) @(negedge clk_i);
    cmp_i = 1'b0;
    @(negedge latch_n_o);
    @(negedge clk_i);
    chk_disp("R9", 1'b1, 3, 1'b0, 1'b1);
    hold_i = 1'b0;

    // R1: reset mid-run clears all
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1", "latch_n", int'(latch_n_o), 1);
    chk_disp("R1", 1'b0, 0, 1'b0, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule